// File: doc/BRIEF.md
# Segmented Parallel Ones Counter

This block reports how many bits are set in a result word. It serves "how many" questions over a bitwise query result: a word arrives with a valid strobe, and two cycles later the count of its set bits leaves with its own valid strobe. The word first lands in a capture register. The captured word is then cut into a fixed number of equal slices, and every slice counts its own set bits at the same time. A balanced tree of adders combines the slice counts, and the total is registered at the output.

The word width and the slice count are parameters. The slice count must be a power of two that divides the word width. Every adder in the tree has the width of the final count. That width is the smallest one able to hold the word width itself, so the tree cannot overflow at any level. A new word may be offered on every cycle. Each word is counted on its own, and nothing is carried over between words.

Top module: `popcnt_seg`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after that edge, `cnt_vld` is 0 and `cnt` is 0. This holds even when words were in flight before the reset.
- R2: `cnt_vld` is 1 exactly at the second rising edge after an edge at which `in_vld` was 1, and it is 0 at every other edge.
- R3: When `cnt_vld` is 1, `cnt` equals the number of 1 bits in the `in_word` that was sampled two edges earlier.
- R4: `cnt` is `$clog2(WORD_W+1)` bits wide. An all-zero word gives 0, and an all-ones word gives exactly `WORD_W`, with no wrap.
- R5: Words offered on consecutive cycles are each counted independently. One valid result comes out per cycle, in input order, with no accumulation.
- R6: The word is cut into `NUM_SEG` slices of `WORD_W/NUM_SEG` bits, where slice s holds bits `[s*SEG_W +: SEG_W]`. Set bits placed anywhere in any one slice, including its lowest and highest bit, are counted correctly.
- R7: When `in_vld` is 0, `in_word` is ignored: two edges later `cnt_vld` is 0 and `cnt` keeps the last valid count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | WORD_W | Word whose set bits are counted |
| cnt_vld | output | 1 | Count output is valid |
| cnt | output | $clog2(WORD_W+1) | Number of set bits in the word |

## Verification
Two functions can meet in the same cycle. One is the output register loading the count of a valid word. The other is either the hold path for an idle slot or a synchronous reset that clears words still in flight. The bench provokes both by mixing random valid gaps with back-to-back bursts, and by asserting reset while valid words sit in both pipeline stages. Each sampled output is compared with a bench model. That model predicts a fresh count, a held count or a cleared state from the valid history two cycles back.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    parameter int DEF_WORD_W  = 64;
    parameter int DEF_NUM_SEG = 8;

    // Width that holds every value from 0 up to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Slice count must be a power of two that divides the word width.
    function automatic bit geom_ok(input int n, input int d);
        return (d > 0) && ((d & (d - 1)) == 0) && ((n % d) == 0);
    endfunction

endpackage

// File: rtl/popcnt_seg_cnt.sv
module popcnt_seg_cnt #(
    parameter int SEG_W = 8,
    parameter int CNT_W = 7
) (
    input  logic [SEG_W-1:0] seg_bits,
    output logic [CNT_W-1:0] seg_ones
);

    always_comb begin
        seg_ones = '0;
        for (int k = 0; k < SEG_W; k++) begin
            seg_ones = seg_ones + CNT_W'(seg_bits[k]);
        end
    end

endmodule

// File: rtl/popcnt_add_tree.sv
module popcnt_add_tree #(
    parameter int NUM_LEAF = 8,
    parameter int CNT_W    = 7
) (
    input  logic [NUM_LEAF*CNT_W-1:0] leaves,
    output logic [CNT_W-1:0]          total
);

    localparam int LVLS = $clog2(NUM_LEAF);

    // Every level uses the same adder width: the full-count width.
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        logic [CNT_W-1:0] node [NUM_LEAF >> l];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < NUM_LEAF; i++) begin : g_in
                assign node[i] = leaves[i*CNT_W +: CNT_W];
            end
        end else begin : g_add
            for (genvar i = 0; i < (NUM_LEAF >> l); i++) begin : g_sum
                assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
            end
        end
    end

    assign total = g_lvl[LVLS].node[0];

endmodule

// File: rtl/popcnt_seg.sv
module popcnt_seg #(
    parameter int WORD_W  = popcnt_pkg::DEF_WORD_W,
    parameter int NUM_SEG = popcnt_pkg::DEF_NUM_SEG
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      in_vld,
    input  logic [WORD_W-1:0]                         in_word,
    output logic                                      cnt_vld,
    output logic [popcnt_pkg::cnt_width(WORD_W)-1:0]  cnt
);

    localparam int SEG_W = WORD_W / NUM_SEG;
    localparam int CNT_W = popcnt_pkg::cnt_width(WORD_W);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } cap_t;

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] ones;
    } res_t;

    cap_t                   cap_q;
    res_t                   res_q;
    logic [NUM_SEG*CNT_W-1:0] seg_flat;
    logic [CNT_W-1:0]       tree_sum;

    // Capture (delay) stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.vld <= in_vld;
            if (in_vld) begin
                cap_q.word <= in_word;
            end
        end
    end

    // Parallel slice counters.
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        popcnt_seg_cnt #(
            .SEG_W (SEG_W),
            .CNT_W (CNT_W)
        ) u_cnt (
            .seg_bits (cap_q.word[s*SEG_W +: SEG_W]),
            .seg_ones (seg_flat[s*CNT_W +: CNT_W])
        );
    end

    popcnt_add_tree #(
        .NUM_LEAF (NUM_SEG),
        .CNT_W    (CNT_W)
    ) u_tree (
        .leaves (seg_flat),
        .total  (tree_sum)
    );

    // Result stage: count is held while no valid word passes.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= cap_q.vld;
            if (cap_q.vld) begin
                res_q.ones <= tree_sum;
            end
        end
    end

    assign cnt_vld = res_q.vld;
    assign cnt     = res_q.ones;

endmodule

// File: rtl/popcnt_seg_chk.sv
module popcnt_seg_chk #(
    parameter int WORD_W  = 64,
    parameter int NUM_SEG = 8,
    parameter int CNT_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_word,
    input logic              cnt_vld,
    input logic [CNT_W-1:0]  cnt
);

    logic [1:0] since_rst;
    logic       hist_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assign hist_ok = (since_rst >= 2'd2);

    initial begin
        a_r6_geometry: assert (popcnt_pkg::geom_ok(WORD_W, NUM_SEG));
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!cnt_vld && (cnt == '0)));

    a_r2_vld_latency: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (cnt_vld == $past(in_vld, 2)));

    a_r3_count_match: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && cnt_vld) |-> (cnt == CNT_W'($countones($past(in_word, 2)))));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !cnt_vld) |-> $stable(cnt));

endmodule

bind popcnt_seg popcnt_seg_chk #(
    .WORD_W  (WORD_W),
    .NUM_SEG (NUM_SEG),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_word (in_word),
    .cnt_vld (cnt_vld),
    .cnt     (cnt)
);

// File: tb/popcnt_seg_tb_top.sv
module popcnt_seg_tb_top;

    localparam int CLK_P   = 10;
    localparam int WORD_W  = 64;
    localparam int NUM_SEG = 8;
    localparam int SEG_W   = WORD_W / NUM_SEG;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic [WORD_W-1:0] in_word = '0;
    logic              cnt_vld;
    logic [CNT_W-1:0]  cnt;

    int n_chk  = 0;
    int n_fail = 0;

    // Model history: stimulus one and two cycles back.
    logic              h1_vld = 1'b0, h2_vld = 1'b0;
    logic [WORD_W-1:0] h1_word = '0, h2_word = '0;
    string             h1_tag = "R2", h2_tag = "R2";
    int                last_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    popcnt_seg #(
        .WORD_W  (WORD_W),
        .NUM_SEG (NUM_SEG)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_word (in_word),
        .cnt_vld (cnt_vld),
        .cnt     (cnt)
    );

    function automatic int ref_ones(input logic [WORD_W-1:0] w);
        int n = 0;
        for (int k = 0; k < WORD_W; k++) n += int'(w[k]);
        return n;
    endfunction

    task automatic check_out();
        int exp_cnt;
        if (h2_vld) last_cnt = ref_ones(h2_word);
        exp_cnt = last_cnt;
        n_chk++;
        if (cnt_vld !== h2_vld) begin
            n_fail++;
            $display("FAIL R2 (%s): cnt_vld=%0b expected %0b", h2_tag, cnt_vld, h2_vld);
        end
        n_chk++;
        if (cnt !== CNT_W'(exp_cnt)) begin
            n_fail++;
            $display("FAIL %s: cnt=%0d expected %0d", h2_tag, cnt, exp_cnt);
        end
    endtask

    // One cycle: check the outputs at the falling edge, then drive new inputs.
    task automatic step(input logic v, input logic [WORD_W-1:0] w, input string tag);
        @(negedge clk);
        check_out();
        h2_vld = h1_vld; h2_word = h1_word; h2_tag = h1_tag;
        h1_vld = v;      h1_word = w;       h1_tag = tag;
        in_vld  = v;
        in_word = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        @(negedge clk);
        n_chk++;
        if (cnt_vld !== 1'b0 || cnt !== '0) begin
            n_fail++;
            $display("FAIL R1: cnt_vld=%0b cnt=%0d expected 0 0", cnt_vld, cnt);
        end
        @(negedge clk);
        rst = 1'b0;
        h1_vld = 1'b0; h2_vld = 1'b0;
        h1_tag = "R1"; h2_tag = "R1";
        last_cnt = 0;
    endtask

    function automatic logic [WORD_W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R4: extreme words.
        step(1'b1, '0, "R4 zero");
        step(1'b1, '1, "R4 all-ones");
        step(1'b0, '0, "R7");
        step(1'b0, '0, "R7");

        // R6: ones confined to one slice, plus its end bits.
        for (int s = 0; s < NUM_SEG; s++) begin
            step(1'b1, {{(WORD_W-SEG_W){1'b0}}, {SEG_W{1'b1}}} << (s*SEG_W), "R6 full slice");
            step(1'b1, WORD_W'(1) << (s*SEG_W), "R6 slice lsb");
            step(1'b1, WORD_W'(1) << (s*SEG_W + SEG_W - 1), "R6 slice msb");
        end

        // R7: garbage on in_word with in_vld low.
        for (int i = 0; i < 6; i++) step(1'b0, rnd_word(), "R7");

        // R5: back-to-back random words.
        for (int i = 0; i < 200; i++) step(1'b1, rnd_word(), "R5");

        // R3/R2: random valid gaps.
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), rnd_word(), "R3");

        // R1: reset with words in both stages.
        step(1'b1, '1, "R1");
        step(1'b1, rnd_word(), "R1");
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, rnd_word(), "R1 after");
        step(1'b1, '1, "R4 all-ones");
        for (int i = 0; i < 3; i++) step(1'b0, '0, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule